// File: doc/BRIEF.md
# Channel Command Descriptor Fetcher

This unit walks a channel program held in word-addressed memory on behalf of one I/O channel. After a start pulse with a byte address, it reads each two-word descriptor. The first word supplies the operation code and a 24-bit data address. The second word supplies a flag byte and a 16-bit transfer length. The unit then presents the resulting command to the device side and waits for the device to report that the command has ended.

Chaining is controlled by the flag byte. A command-chain flag makes the unit move on to the next descriptor once the current one ends, and that descriptor brings a fresh operation. A data-chain flag also continues the program, but the operation code of the following descriptor is discarded and the running operation continues with a new buffer. A transfer-in-channel descriptor redirects the list pointer to another place in memory. It is rejected with a program check when it opens a list or follows another transfer. An operation code of zero initializes the channel, and the unit then captures the status buffer address offered for the device.

Top module: `cmd_desc_fetch`

## Requirements
- R1: After reset the unit is idle: busy, cmd_valid, new_cmd, prog_check, chan_end and mem_rd_en are 0, and cmd_code is 0.
- R2: On start, the first descriptor word is read at word index list_addr>>2 and the second word at the next index. Each read returns its data one cycle after mem_rd_en.
- R3: The presented fields are taken as follows: cmd_code from word1[31:24], cmd_addr from word1[23:0], cmd_flags from word2[31:24] and cmd_count from word2[15:0]. In cmd_flags, bit 7 is command chain and bit 6 is data chain.
- R4: A descriptor whose word1[27:24] equals 4'h8 is a transfer. It issues no command, and fetching resumes at byte address word1[23:0].
- R5: A transfer that is the first descriptor of a list, or that directly follows another transfer, sets prog_check and returns the unit to idle without presenting a command.
- R6: When the previous descriptor carried the data-chain flag, the new descriptor's operation code is ignored: cmd_code keeps its value and new_cmd stays 0.
- R7: When a command is loaded without data chaining, new_cmd is 1 for exactly the first cycle in which cmd_valid is 1.
- R8: dev_done while cmd_valid is 1 drops cmd_valid and sets chan_end. It clears cmd_code unless data chaining follows. If either chain flag is set, the unit fetches the descriptor 8 bytes further on; otherwise it goes idle.
- R9: A loaded operation code of 8'h00 copies init_buf_addr into stat_buf_addr.
- R10: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a channel program |
| list_addr | input | 24 | Byte address of the first descriptor |
| init_buf_addr | input | 24 | Status buffer address captured by an initialize command |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_idx | output | 22 | Memory word index |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| dev_done | input | 1 | Device reports channel end or device end |
| busy | output | 1 | A channel program is running |
| cmd_valid | output | 1 | A command is presented to the device |
| new_cmd | output | 1 | The presented command is a new operation |
| cmd_code | output | 8 | Active operation code |
| cmd_addr | output | 24 | Data address |
| cmd_flags | output | 8 | Flag byte |
| cmd_count | output | 16 | Transfer length |
| prog_check | output | 1 | Illegal transfer placement detected |
| chan_end | output | 1 | The last command ended |
| stat_buf_addr | output | 24 | Latched status buffer address |

## Verification
The bench builds the unit with its default parameters: 24-bit byte addresses, which give 22-bit word indices, a 16-bit length field and transfer code 4'h8. The memory model answers only the low 256 words, and this is enough to place lists, jump targets and chained descriptors in separate regions. With these values, the bench can check a transfer target that lies outside the list, a double transfer, and a data chain whose discarded operation code differs from the running one.

// File: rtl/cmd_desc_fetch.sv
module cmd_desc_fetch #(
  parameter int AW = 24,
  parameter int NW = 16,
  parameter logic [3:0] TIC_CODE = 4'h8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] list_addr,
  input  logic [AW-1:0] init_buf_addr,
  output logic          mem_rd_en,
  output logic [AW-3:0] mem_rd_idx,
  input  logic [31:0]   mem_rd_data,
  input  logic          dev_done,
  output logic          busy,
  output logic          cmd_valid,
  output logic          new_cmd,
  output logic [7:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_flags,
  output logic [NW-1:0] cmd_count,
  output logic          prog_check,
  output logic          chan_end,
  output logic [AW-1:0] stat_buf_addr
);
  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_DISP, S_WAIT} st_t;
  localparam int CC_BIT = 7;
  localparam int DC_BIT = 6;

  st_t st;
  logic [AW-1:0] ptr;
  logic [31:0]   w1_q;
  logic          first_q, tic_q, dc_q;

  wire          is_tic   = mem_rd_data[27:24] == TIC_CODE;
  wire [AW-1:0] ptr_w2   = ptr + AW'(4);
  wire          chaining = cmd_flags[CC_BIT] | cmd_flags[DC_BIT];

  assign busy       = st != S_IDLE;
  assign mem_rd_en  = (st == S_RD1) || (st == S_RD2 && !is_tic);
  assign mem_rd_idx = (st == S_RD1) ? ptr[AW-1:2] : ptr_w2[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0;
      w1_q <= '0;
      first_q <= 1'b0;
      tic_q <= 1'b0;
      dc_q <= 1'b0;
      cmd_valid <= 1'b0;
      new_cmd <= 1'b0;
      cmd_code <= '0;
      cmd_addr <= '0;
      cmd_flags <= '0;
      cmd_count <= '0;
      prog_check <= 1'b0;
      chan_end <= 1'b0;
      stat_buf_addr <= '0;
    end else begin
      new_cmd <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ptr <= list_addr;
          first_q <= 1'b1;
          tic_q <= 1'b0;
          dc_q <= 1'b0;
          prog_check <= 1'b0;
          chan_end <= 1'b0;
          cmd_code <= '0;
          st <= S_RD1;
        end
        S_RD1: st <= S_RD2;
        S_RD2: begin
          if (is_tic) begin
            if (first_q || tic_q) begin
              prog_check <= 1'b1;
              st <= S_IDLE;
            end else begin
              ptr <= mem_rd_data[AW-1:0];
              tic_q <= 1'b1;
              st <= S_RD1;
            end
          end else begin
            w1_q <= mem_rd_data;
            first_q <= 1'b0;
            tic_q <= 1'b0;
            st <= S_DISP;
          end
        end
        S_DISP: begin
          cmd_addr <= w1_q[AW-1:0];
          cmd_flags <= mem_rd_data[31:24];
          cmd_count <= mem_rd_data[NW-1:0];
          if (!dc_q) begin
            cmd_code <= w1_q[31:24];
            new_cmd <= 1'b1;
            if (w1_q[31:24] == 8'h00) stat_buf_addr <= init_buf_addr;
          end
          dc_q <= mem_rd_data[24+DC_BIT];
          ptr <= ptr + AW'(8);
          chan_end <= 1'b0;
          cmd_valid <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: if (dev_done) begin
          cmd_valid <= 1'b0;
          chan_end <= 1'b1;
          if (!dc_q) cmd_code <= '0;
          st <= chaining ? S_RD1 : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cmd_desc_fetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_rd_en,
  input logic       cmd_valid,
  input logic       new_cmd,
  input logic [7:0] cmd_code,
  input logic       dev_done,
  input logic       chan_end,
  input logic       prog_check
);
  a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en);
  a_r5_check_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_check) |-> !busy && !cmd_valid);
  a_r7_new_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    new_cmd |-> cmd_valid);
  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !new_cmd |-> $stable(cmd_code));
  a_r8_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && dev_done |=> !cmd_valid && chan_end);
  a_r8_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

bind cmd_desc_fetch cmd_desc_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en),
  .cmd_valid(cmd_valid), .new_cmd(new_cmd), .cmd_code(cmd_code),
  .dev_done(dev_done), .chan_end(chan_end), .prog_check(prog_check)
);

// File: tb/cmd_desc_fetch_bench.sv
module cmd_desc_fetch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] list_addr = '0;
  logic [23:0] init_buf_addr = '0;
  logic mem_rd_en;
  logic [21:0] mem_rd_idx;
  logic [31:0] mem_rd_data = '0;
  logic dev_done = 1'b0;
  logic busy, cmd_valid, new_cmd, prog_check, chan_end;
  logic [7:0] cmd_code, cmd_flags;
  logic [23:0] cmd_addr, stat_buf_addr;
  logic [15:0] cmd_count;
  logic [31:0] mem [0:255];
  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cmd_desc_fetch u_cmd_desc_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .list_addr(list_addr),
    .init_buf_addr(init_buf_addr), .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx),
    .mem_rd_data(mem_rd_data), .dev_done(dev_done), .busy(busy),
    .cmd_valid(cmd_valid), .new_cmd(new_cmd), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_flags(cmd_flags), .cmd_count(cmd_count),
    .prog_check(prog_check), .chan_end(chan_end), .stat_buf_addr(stat_buf_addr)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_idx[7:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [23:0] a, input logic [31:0] w1, input logic [31:0] w2);
    mem[a[9:2]] = w1;
    mem[a[9:2] + 8'd1] = w2;
  endtask

  task automatic kick(input logic [23:0] a);
    @(negedge clk);
    start = 1'b1;
    list_addr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!cmd_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(cmd_valid), 32'd1);
  endtask

  task automatic end_cmd(input string req);
    dev_done = 1'b1;
    @(negedge clk);
    dev_done = 1'b0;
    chk(req, {30'd0, cmd_valid, chan_end}, 32'd1);
  endtask

  task automatic settle(input int cycles);
    for (int i = 0; i < cycles; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 idle outputs", {26'd0, busy, cmd_valid, new_cmd, prog_check, chan_end, mem_rd_en}, 32'd0);
    chk("R1 code", 32'(cmd_code), 32'd0);
  endtask

  task automatic t_single;
    put(24'h040, 32'h03_000100, 32'h00_00_0010);
    kick(24'h040);
    wait_valid("R2 single valid");
    chk("R3 code", 32'(cmd_code), 32'h03);
    chk("R3 addr", 32'(cmd_addr), 32'h100);
    chk("R3 count", 32'(cmd_count), 32'h10);
    chk("R7 new pulse", 32'(new_cmd), 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(new_cmd), 32'd0);
    start = 1'b1; list_addr = 24'h200;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start ignored", {cmd_valid, cmd_code}, {1'b1, 8'h03});
    end_cmd("R8 end single");
    chk("R8 code cleared", 32'(cmd_code), 32'd0);
    settle(6);
    chk("R10 no restart", {30'd0, busy, prog_check}, 32'd0);
  endtask

  task automatic t_cmd_chain;
    put(24'h080, 32'h01_000400, 32'h80_00_0020);
    put(24'h088, 32'h02_000500, 32'h00_00_0030);
    kick(24'h080);
    wait_valid("R2 chain first");
    chk("R3 flags", 32'(cmd_flags), 32'h80);
    end_cmd("R8 chain first end");
    chk("R8 chain continues", 32'(busy), 32'd1);
    wait_valid("R8 chain second");
    chk("R8 next at +8", {cmd_code, cmd_addr}, {8'h02, 24'h000500});
    chk("R7 new on chain", 32'(new_cmd), 32'd1);
    end_cmd("R8 chain second end");
    settle(2);
    chk("R8 idle after last", 32'(busy), 32'd0);
  endtask

  task automatic t_data_chain;
    put(24'h0C0, 32'h05_000200, 32'h40_00_0004);
    put(24'h0C8, 32'h07_000300, 32'h00_00_0008);
    kick(24'h0C0);
    wait_valid("R6 dc first");
    end_cmd("R6 dc first end");
    chk("R8 code kept for dc", 32'(cmd_code), 32'h05);
    wait_valid("R6 dc second");
    chk("R6 code kept", 32'(cmd_code), 32'h05);
    chk("R6 no new", 32'(new_cmd), 32'd0);
    chk("R6 new addr count", {cmd_addr, 8'h00}, {24'h000300, 8'h00});
    chk("R6 count", 32'(cmd_count), 32'd8);
    end_cmd("R6 dc end");
    settle(2);
  endtask

  task automatic t_tic_mid;
    put(24'h100, 32'h01_000010, 32'h80_00_0001);
    put(24'h108, 32'h08_000180, 32'h0);
    put(24'h180, 32'h0A_000777, 32'h00_00_0002);
    kick(24'h100);
    wait_valid("R4 before tic");
    end_cmd("R4 first end");
    wait_valid("R4 after tic");
    chk("R4 target fetched", {cmd_code, cmd_addr}, {8'h0A, 24'h000777});
    chk("R4 no check", 32'(prog_check), 32'd0);
    end_cmd("R4 end");
    settle(2);
  endtask

  task automatic t_tic_lead;
    put(24'h200, 32'h08_000300, 32'h0);
    kick(24'h200);
    settle(8);
    chk("R5 lead tic", {29'd0, prog_check, busy, cmd_valid}, 32'd4);
  endtask

  task automatic t_tic_double;
    put(24'h220, 32'h01_000010, 32'h80_00_0001);
    put(24'h228, 32'h08_000240, 32'h0);
    put(24'h240, 32'h08_000260, 32'h0);
    put(24'h260, 32'h0C_000000, 32'h0);
    kick(24'h220);
    chk("R5 check cleared on start", 32'(prog_check), 32'd0);
    wait_valid("R5 double first");
    end_cmd("R5 double first end");
    settle(12);
    chk("R5 double tic", {29'd0, prog_check, busy, cmd_valid}, 32'd4);
  endtask

  task automatic t_init;
    init_buf_addr = 24'h123456;
    put(24'h280, 32'h00_000000, 32'h00_00_0000);
    kick(24'h280);
    wait_valid("R9 init valid");
    chk("R9 buf latched", 32'(stat_buf_addr), 32'h123456);
    init_buf_addr = 24'h0;
    end_cmd("R9 end");
    settle(2);
    chk("R9 buf held", 32'(stat_buf_addr), 32'h123456);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    settle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_cmd_chain;
    t_data_chain;
    t_tic_mid;
    t_tic_lead;
    t_tic_double;
    t_init;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule